// File: doc/BRIEF.md
# Watchdog Timer with Postscaler

This block guards a device against software that has stopped running its main loop. In watchdog mode a base counter advances on each tick of an independent slow oscillator. The oscillator is not part of the block and reaches it as a clock-enable input. A postscaler divides the base counter's wraps by 1, 64 or 256. When the selected tap overflows, the block emits a one-cycle device-reset request and drops an active-low time-out flag. Software prevents this by issuing the clear-watchdog command more often than the shortest overflow period.

A 2-bit configuration select chooses the postscaler ratio. Its zero code disables the reset function altogether. With the zero code the block becomes a plain overflow timer: it counts every device clock while the device is awake, only drops the time-out flag on overflow, and never asks for a reset.

The base counter and the postscaler are cleared by any of four events: the device reset state, the sleep command, the clear-watchdog command, or a wake-up caused by an interrupt. The time-out flag is preserved across a device reset, so software can read back the cause of the reset afterwards. Neither counter can be read or written by software.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset (rst_ni low), to_n_o is 1 and rst_req_o is 0.
- R2: With cfg_i equal to 01, 10 or 11, rst_req_o is raised after 2^BASE_W, 64·2^BASE_W or 256·2^BASE_W oscillator ticks respectively, counted from the last clear.
- R3: In watchdog mode only clock edges with osc_tick_i high advance the count; other edges leave it unchanged.
- R4: rst_req_o is high for exactly one cycle. It rises on the clock edge that takes the final counted tick.
- R5: An edge where dev_rst_i, clrwdt_i, sleep_i or wake_irq_i is high clears the base counter and the postscaler and does not count. Counting resumes on the first edge where all four are low.
- R6: In watchdog mode counting continues after a sleep command, and an overflow while asleep still raises rst_req_o.
- R7: An overflow in either mode drives to_n_o to 0 on the same edge as the overflow.
- R8: dev_rst_i does not change to_n_o. The flag returns to 1 only through clrwdt_i or rst_ni.
- R9: With cfg_i equal to 00, the counter advances on every awake clock edge whatever osc_tick_i is. It overflows after 2^TMR_W cycles, and rst_req_o stays 0.
- R10: With cfg_i equal to 00, the counter holds from a sleep command until wake_irq_i or dev_rst_i ends sleep.
- R11: clrwdt_i sets to_n_o to 1 in both modes. When it coincides with what would have been the overflowing tick, no overflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| cfg_i | input | 2 | 00 plain timer, 01 ratio 1:1, 10 ratio 1:64, 11 ratio 1:256 |
| osc_tick_i | input | 1 | One-cycle enable per tick of the slow oscillator |
| dev_rst_i | input | 1 | Device is held in its reset state |
| clrwdt_i | input | 1 | Clear-watchdog command executed |
| sleep_i | input | 1 | Sleep command executed |
| wake_irq_i | input | 1 | Wake from sleep caused by an interrupt |
| to_n_o | output | 1 | Time-out flag, 0 after an overflow |
| rst_req_o | output | 1 | One-cycle device-reset request |

## Verification
Overflow is driven with a continuous tick stream at each of the three ratios, which tells apart a wrong tap or ratio. It is also driven with ticks spaced apart, which shows whether idle cycles are wrongly counted. Each clear source in turn is applied part-way through a count and must push the expected pulse out by exactly one full period. A clear that lands on the would-be overflowing tick tests the priority between clear and count. In timer mode the bench holds osc_tick_i low and holds sleep beyond one period, which separates clock counting from tick counting and shows whether the sleep stall works.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    CFG_TIMER  = 2'b00,
    CFG_DIV1   = 2'b01,
    CFG_DIV64  = 2'b10,
    CFG_DIV256 = 2'b11
  } wdog_cfg_e;

  function automatic logic is_wdog(wdog_cfg_e c);
    return c != CFG_TIMER;
  endfunction
endpackage

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (inc_i)    cnt_q <= cnt_q + 1'b1;
  end

  // clear dominates the increment
  assign wrap_o = inc_i & ~clr_i & (&cnt_q);
endmodule

// File: rtl/wdog_post.sv
module wdog_post
  import wdog_pkg::*;
#(
  parameter int POST_W  = 8,
  parameter int MID_LOG = 6
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      base_wrap_i,
  input  wdog_cfg_e sel_i,
  output logic      ovf_o
);
  localparam int NTAP = 4;

  logic [POST_W-1:0] pcnt_q;
  logic [NTAP-1:0]   tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pcnt_q <= '0;
    else if (clr_i)       pcnt_q <= '0;
    else if (base_wrap_i) pcnt_q <= pcnt_q + 1'b1;
  end

  assign tap[CFG_TIMER] = 1'b0;
  assign tap[CFG_DIV1]  = base_wrap_i;

  generate
    if (MID_LOG > 0) begin : g_mid
      assign tap[CFG_DIV64] = base_wrap_i & (&pcnt_q[MID_LOG-1:0]);
    end else begin : g_mid_none
      assign tap[CFG_DIV64] = base_wrap_i;
    end
  endgenerate

  assign tap[CFG_DIV256] = base_wrap_i & (&pcnt_q);
  assign ovf_o = tap[sel_i];
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dev_rst_i,
  input  logic sleep_i,
  input  logic wake_irq_i,
  input  logic clrwdt_i,
  input  logic wdog_mode_i,
  input  logic wdt_ovf_i,
  input  logic tmr_ovf_i,
  output logic asleep_o,
  output logic to_n_o,
  output logic rst_req_o
);
  logic asleep_q, to_n_q, req_q;
  logic ovf_any;

  assign ovf_any = (wdog_mode_i & wdt_ovf_i) | (~wdog_mode_i & tmr_ovf_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asleep_q <= 1'b0;
      to_n_q   <= 1'b1;
      req_q    <= 1'b0;
    end else begin
      asleep_q <= (asleep_q | sleep_i) & ~(wake_irq_i | dev_rst_i);
      // flag survives device reset; only clear-watchdog restores it
      if (clrwdt_i)     to_n_q <= 1'b1;
      else if (ovf_any) to_n_q <= 1'b0;
      req_q <= wdog_mode_i & wdt_ovf_i;
    end
  end

  assign asleep_o  = asleep_q;
  assign to_n_o    = to_n_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int BASE_W  = 12,
  parameter int TMR_W   = 16,
  parameter int POST_W  = 8,
  parameter int MID_LOG = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cfg_i,
  input  logic       osc_tick_i,
  input  logic       dev_rst_i,
  input  logic       clrwdt_i,
  input  logic       sleep_i,
  input  logic       wake_irq_i,
  output logic       to_n_o,
  output logic       rst_req_o
);
  wdog_cfg_e cfg;
  logic wdog_mode, clr, asleep;
  logic base_inc, base_wrap, wdt_ovf;
  logic tmr_inc, tmr_ovf;

  assign cfg       = wdog_cfg_e'(cfg_i);
  assign wdog_mode = is_wdog(cfg);
  assign clr       = dev_rst_i | sleep_i | clrwdt_i | wake_irq_i;
  assign base_inc  = wdog_mode & osc_tick_i;
  assign tmr_inc   = ~wdog_mode & ~asleep;

  wdog_cnt #(.W(BASE_W)) u_base (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .inc_i (base_inc), .wrap_o(base_wrap)
  );

  wdog_post #(.POST_W(POST_W), .MID_LOG(MID_LOG)) u_post (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .base_wrap_i(base_wrap), .sel_i(cfg), .ovf_o(wdt_ovf)
  );

  wdog_cnt #(.W(TMR_W)) u_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .inc_i (tmr_inc), .wrap_o(tmr_ovf)
  );

  wdog_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dev_rst_i  (dev_rst_i),
    .sleep_i    (sleep_i),
    .wake_irq_i (wake_irq_i),
    .clrwdt_i   (clrwdt_i),
    .wdog_mode_i(wdog_mode),
    .wdt_ovf_i  (wdt_ovf),
    .tmr_ovf_i  (tmr_ovf),
    .asleep_o   (asleep),
    .to_n_o     (to_n_o),
    .rst_req_o  (rst_req_o)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] cfg_i,
  input logic       osc_tick_i,
  input logic       dev_rst_i,
  input logic       clrwdt_i,
  input logic       sleep_i,
  input logic       wake_irq_i,
  input logic       to_n_o,
  input logic       rst_req_o
);
  a_r4_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  a_r7_req_drops_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !to_n_o);

  a_r5_clear_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_rst_i || clrwdt_i || sleep_i || wake_irq_i) |=> !rst_req_o);

  a_r3_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i != 2'b00 && !osc_tick_i) |=> !rst_req_o);

  a_r9_timer_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i == 2'b00 && $stable(cfg_i)) |-> !rst_req_o);

  a_r11_clr_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clrwdt_i |=> to_n_o);

  a_r8_flag_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(to_n_o) |-> $past(clrwdt_i));
endmodule

bind wdog_timer wdog_timer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_i     (cfg_i),
  .osc_tick_i(osc_tick_i),
  .dev_rst_i (dev_rst_i),
  .clrwdt_i  (clrwdt_i),
  .sleep_i   (sleep_i),
  .wake_irq_i(wake_irq_i),
  .to_n_o    (to_n_o),
  .rst_req_o (rst_req_o)
);

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 4;
  localparam int TW = 10;
  localparam int BASE = 1 << BW;
  localparam int TPER = 1 << TW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg = 2'b01;
  logic osc = 1'b0, dev_rst = 1'b0, clrwdt = 1'b0, slp = 1'b0, wake = 1'b0;
  logic to_n, rst_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer #(.BASE_W(BW), .TMR_W(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .osc_tick_i(osc),
    .dev_rst_i(dev_rst), .clrwdt_i(clrwdt), .sleep_i(slp),
    .wake_irq_i(wake), .to_n_o(to_n), .rst_req_o(rst_req)
  );

  int cyc = 0;
  int checks = 0;
  int errs = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; string tag; } exp_t;
  exp_t exp_q[$];

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: every reset request must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && rst_req) begin
      if (exp_q.size() == 0) begin
        checks++; errs++;
        $display("FAIL R4 unexpected rst_req at cycle actual=%0d expected=none", cyc);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cyc == e.at, e.tag, cyc, e.at);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(string tag);
    checks++;
    if (exp_q.size() != 0) begin
      errs++;
      $display("FAIL %s pending pulses actual=%0d expected=0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); clrwdt = 1'b1;
    @(negedge clk); clrwdt = 1'b0;
  endtask

  // kind 0 clear-watchdog, 1 sleep, 2 wake; continuous ticks, pulse n ticks later
  task automatic run_cont(int kind, int n, string tag);
    @(negedge clk);
    osc = 1'b1;
    case (kind)
      0: clrwdt = 1'b1;
      1: slp = 1'b1;
      default: wake = 1'b1;
    endcase
    exp_q.push_back('{cyc + 1 + n, tag});
    @(negedge clk);
    clrwdt = 1'b0; slp = 1'b0; wake = 1'b0;
    repeat (n) @(negedge clk);
    osc = 1'b0;
    idle(3);
    drained(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check(to_n == 1'b1, "R1 to_n after reset", to_n, 1);
    check(rst_req == 1'b0, "R1 rst_req after reset", rst_req, 0);

    // R5: counting starts on first edge after leaving device reset
    dev_rst = 1'b1; osc = 1'b1;
    idle(5);
    @(negedge clk);
    dev_rst = 1'b0;
    exp_q.push_back('{cyc + BASE, "R5 start after reset"});
    repeat (BASE) @(negedge clk);
    osc = 1'b0;
    idle(3);
    drained("R5 start after reset");
    check(to_n == 1'b0, "R7 flag after overflow", to_n, 0);

    // R8: device reset keeps the flag
    @(negedge clk); dev_rst = 1'b1;
    @(negedge clk); dev_rst = 1'b0;
    idle(2);
    check(to_n == 1'b0, "R8 flag held over dev_rst", to_n, 0);
    pulse_clr();
    check(to_n == 1'b1, "R11 clrwdt sets flag", to_n, 1);

    // R2: the three ratios
    run_cont(0, BASE, "R2 ratio 1");
    check(to_n == 1'b0, "R7 flag ratio 1", to_n, 0);
    pulse_clr();
    cfg = 2'b10;
    run_cont(0, BASE * 64, "R2 ratio 64");
    pulse_clr();
    cfg = 2'b11;
    run_cont(0, BASE * 256, "R2 ratio 256");
    check(to_n == 1'b0, "R7 flag ratio 256", to_n, 0);
    pulse_clr();
    cfg = 2'b01;

    // R3: sparse ticks, idle edges not counted
    pulse_clr();
    for (int i = 0; i < BASE; i++) begin
      @(negedge clk);
      osc = 1'b1;
      if (i == BASE - 1) exp_q.push_back('{cyc + 1, "R3 sparse ticks"});
      @(negedge clk);
      osc = 1'b0;
      idle(2);
    end
    idle(2);
    drained("R3 sparse ticks");
    pulse_clr();

    // R11: clear on the would-be overflowing tick wins
    @(negedge clk); clrwdt = 1'b1; osc = 1'b1;
    @(negedge clk); clrwdt = 1'b0;
    repeat (BASE - 1) @(negedge clk);
    clrwdt = 1'b1;
    @(negedge clk); clrwdt = 1'b0; osc = 1'b0;
    idle(BASE + 4);
    drained("R11 clear beats overflow");
    check(to_n == 1'b1, "R11 flag after race", to_n, 1);

    // R5: regular servicing keeps it from firing
    osc = 1'b1;
    for (int i = 0; i < 20; i++) begin
      pulse_clr();
      idle(BASE - 8);
    end
    osc = 1'b0;
    idle(2);
    drained("R5 serviced");
    check(to_n == 1'b1, "R5 flag while serviced", to_n, 1);

    // R6: counting continues in sleep
    run_cont(1, BASE, "R6 overflow in sleep");
    @(negedge clk); dev_rst = 1'b1;
    @(negedge clk); dev_rst = 1'b0;
    pulse_clr();

    // R5: wake by interrupt restarts the period
    @(negedge clk); clrwdt = 1'b1; osc = 1'b1;
    @(negedge clk); clrwdt = 1'b0;
    repeat (BASE - 6) @(negedge clk);
    run_cont(2, BASE, "R5 wake clears");

    // R9: plain timer counts clocks without ticks
    cfg = 2'b00; osc = 1'b0;
    pulse_clr();
    repeat (TPER - 1) @(negedge clk);
    check(to_n == 1'b1, "R9 flag before timer overflow", to_n, 1);
    @(negedge clk);
    check(to_n == 1'b0, "R9 flag at timer overflow", to_n, 0);
    check(rst_req == 1'b0, "R9 no reset request", rst_req, 0);
    pulse_clr();
    check(to_n == 1'b1, "R11 clrwdt sets flag in timer mode", to_n, 1);

    // R10: timer stalls in sleep, resumes after wake
    @(negedge clk); slp = 1'b1;
    @(negedge clk); slp = 1'b0;
    idle(TPER + 400);
    check(to_n == 1'b1, "R10 no overflow while asleep", to_n, 1);
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    repeat (TPER - 1) @(negedge clk);
    check(to_n == 1'b1, "R10 flag before overflow after wake", to_n, 1);
    @(negedge clk);
    check(to_n == 1'b0, "R10 overflow after wake", to_n, 0);
    idle(3);
    drained("R9 timer mode no pulses");

    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule